// File: doc/BRIEF.md
# Bus Idle Quiet-Time Detector

This block watches a bus for silence. It keeps its own tally of outstanding transactions: an accepted request adds one and a completed response takes one away. It also runs a 24-bit down counter. Whenever any transaction is outstanding, the counter is refilled every cycle with a value derived from a programmable quiet-time setting. Once the bus goes idle, the counter counts down by one per clock. When it reaches zero it stays there, and if the enable bit is set, an interrupt request goes to core 0.

Software uses the request to gain reasonable confidence that traffic from the processor cluster has stopped. For example, it can wait for the request before it changes a clock or power domain on the far side of the bus. The quiet-time setting is given in units of sixteen bus clocks. The reload value is sixteen times the setting plus fifteen, so even a setting of zero needs fifteen idle cycles.

Top module: `quietTimer`

## Requirements
- R1: `rstN` is an active-low synchronous reset. While it is low, the outstanding tally clears and the counter loads the reload value of the setting present at that edge. After reset the request is low.
- R2: The outstanding tally rises by one on a cycle with `reqAccept` alone, falls by one on a cycle with `rspDone` alone, and is unchanged when both are high. A lone `rspDone` while the tally is zero is ignored.
- R3: The bus counts as busy in a cycle if the tally is nonzero or `reqAccept` is high. In every busy cycle the counter loads 16*S+15, where S is `quietCtrlWord[19:0]`.
- R4: In a cycle that is not busy and has a nonzero counter, the counter decreases by exactly one.
- R5: A counter at zero stays at zero, with no wrap, until the next busy cycle.
- R6: `core0QuietIrq` is high exactly when `quietCtrlWord[20]` is 1 and the counter is zero. A change of the enable bit takes effect in the same cycle.
- R7: After the clock edge of any busy cycle, the request is low.
- R8: A change of S while the counter is counting down does not alter the countdown in progress. The new S takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqAccept | input | 1 | A bus request was accepted this cycle |
| rspDone | input | 1 | A bus response completed this cycle |
| quietCtrlWord | input | 21 | Bits 19:0 quiet-time setting in units of 16 clocks; bit 20 request enable |
| core0QuietIrq | output | 1 | Quiet-time interrupt request to core 0 |

## Verification
The bench targets the exact cycle where the request rises after the last response. A reload off by the fifteen-cycle offset or by the ×16 scaling moves that edge, and the per-cycle comparison catches it. A stray response while nothing is outstanding is sent to expose an underflowing tally, which would hold the bus busy forever and never raise the request. The bench also sends a request and a response in the same cycle, and leaves a request open across a long gap, to catch a tally that loses count. Finally, the bench changes the setting in the middle of a countdown and toggles the enable while the counter sits at zero. A design that reloads on a setting change would fire late, and one that wraps below zero or registers the enable would fire in the wrong cycles.

// File: rtl/quietPkg.sv
package quietPkg;
  // Strobes from control to datapath; at most one is high in a cycle
  typedef struct packed {
    logic load;
    logic dec;
  } quietStrobe_t;
endpackage

// File: rtl/quietDatapath.sv
module quietDatapath
  import quietPkg::*;
#(
  parameter int SET_W   = 20,
  parameter int SCALE_W = 4,
  parameter int CNT_W   = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  quietStrobe_t     strb,
  input  logic [SET_W-1:0] setting,
  output logic             cntZero
);
  localparam int RELOAD_W = SET_W + SCALE_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reloadVal;

  // reload = setting * 2^SCALE_W + (2^SCALE_W - 1)
  generate
    if (CNT_W > RELOAD_W) begin : g_pad
      assign reloadVal = {{(CNT_W-RELOAD_W){1'b0}}, setting, {SCALE_W{1'b1}}};
    end else begin : g_exact
      logic [RELOAD_W-1:0] fullVal;
      assign fullVal   = {setting, {SCALE_W{1'b1}}};
      assign reloadVal = fullVal[CNT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.load)
      cnt <= reloadVal;
    else if (strb.dec)
      cnt <= cnt - CNT_W'(1);
  end

  assign cntZero = (cnt == '0);

  // R3
  reload_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> cnt == $past(reloadVal));
  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |=> cnt == $past(cnt) - CNT_W'(1));
  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntZero && !strb.load) |=> cntZero);
endmodule

// File: rtl/quietCtrl.sv
module quietCtrl
  import quietPkg::*;
#(
  parameter int PEND_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqAccept,
  input  logic         rspDone,
  input  logic         cntZero,
  input  logic         irqEn,
  output quietStrobe_t strb,
  output logic         irq
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pendCnt;
  logic              busy;

  always_ff @(posedge clk) begin
    if (!rstN)
      pendCnt <= '0;
    else if (reqAccept && !rspDone && pendCnt != PEND_MAX)
      pendCnt <= pendCnt + PEND_W'(1);
    else if (!reqAccept && rspDone && pendCnt != '0)
      pendCnt <= pendCnt - PEND_W'(1);
  end

  assign busy = (pendCnt != '0) || reqAccept;

  always_comb begin
    strb      = '0;
    strb.load = !rstN || busy;
    strb.dec  = rstN && !busy && !cntZero;
  end

  assign irq = irqEn && cntZero;

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt == '0 && rspDone && !reqAccept) |=> pendCnt == '0);
  // R7
  traffic_irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !irq);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/quietTimer.sv
module quietTimer
  import quietPkg::*;
#(
  parameter int SET_W   = 20,
  parameter int SCALE_W = 4,
  parameter int CNT_W   = 24,
  parameter int PEND_W  = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqAccept,
  input  logic           rspDone,
  input  logic [SET_W:0] quietCtrlWord,
  output logic           core0QuietIrq
);
  localparam int EN_BIT = SET_W;

  quietStrobe_t strb;
  logic         cntZero;

  quietCtrl #(.PEND_W(PEND_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqAccept(reqAccept),
    .rspDone  (rspDone),
    .cntZero  (cntZero),
    .irqEn    (quietCtrlWord[EN_BIT]),
    .strb     (strb),
    .irq      (core0QuietIrq)
  );

  quietDatapath #(.SET_W(SET_W), .SCALE_W(SCALE_W), .CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .setting(quietCtrlWord[SET_W-1:0]),
    .cntZero(cntZero)
  );
endmodule

// File: tb/tb_quietTimer.sv
module tb_quietTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqAccept = 1'b0;
  logic        rspDone = 1'b0;
  logic [20:0] quietCtrlWord = 21'd0;
  logic        core0QuietIrq;

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  bit started = 0;
  bit finished = 0;
  string curTag = "R1";

  // reference model state
  int mPend = 0;
  longint mCnt = 0;

  quietTimer dut (
    .clk(clk), .rstN(rstN), .reqAccept(reqAccept), .rspDone(rspDone),
    .quietCtrlWord(quietCtrlWord), .core0QuietIrq(core0QuietIrq)
  );

  always #2.5 clk = ~clk;

  function automatic longint reloadOf(logic [20:0] w);
    return longint'(w[19:0]) * 16 + 15;
  endfunction

  always @(posedge clk) begin
    bit isBusy;
    cycle <= cycle + 1;
    started <= 1'b1;
    if (!rstN) begin
      mPend = 0;
      mCnt = reloadOf(quietCtrlWord);
    end else begin
      isBusy = (mPend > 0) || reqAccept;
      if (reqAccept && !rspDone) mPend = mPend + 1;
      else if (!reqAccept && rspDone && mPend > 0) mPend = mPend - 1;
      if (isBusy) mCnt = reloadOf(quietCtrlWord);
      else if (mCnt > 0) mCnt = mCnt - 1;
    end
  end

  always @(negedge clk) begin
    bit expIrq;
    if (started && !finished) begin
      expIrq = quietCtrlWord[20] && (mCnt == 0);
      checks++;
      if (core0QuietIrq !== expIrq) begin
        errors++;
        $display("FAIL %s irq=%0b expected %0b at cycle %0d", curTag, core0QuietIrq, expIrq, cycle);
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulseAcc(bit done);
    reqAccept = 1'b1; rspDone = done; step(1);
    reqAccept = 1'b0; rspDone = 1'b0;
  endtask

  task automatic pulseDone();
    rspDone = 1'b1; step(1); rspDone = 1'b0;
  endtask

  initial begin
    // R1: reset with enable set, setting 1 (reload 31)
    curTag = "R1";
    quietCtrlWord = {1'b1, 20'd1};
    step(3);
    rstN = 1'b1;
    // R4 then R5: idle countdown to zero and hold there
    curTag = "R4"; step(30);
    curTag = "R5"; step(15);
    // R6: enable toggled while counter sits at zero
    curTag = "R6";
    quietCtrlWord[20] = 1'b0; step(4);
    quietCtrlWord[20] = 1'b1; step(4);
    // R7 and R3: one transaction open for five cycles, then countdown
    curTag = "R7"; pulseAcc(0); step(4);
    curTag = "R3"; pulseDone(); step(40);
    // R2: two open, one closed, long gap; must stay busy
    curTag = "R2";
    pulseAcc(0); pulseAcc(0); step(2); pulseDone(); step(50);
    pulseDone(); step(40);
    // R2: stray response with nothing outstanding is ignored
    pulseDone(); step(40);
    // R2: request and response in same cycle
    pulseAcc(1); step(40);
    // R8: setting change mid-countdown does not alter it
    curTag = "R8";
    pulseAcc(1); step(10);
    quietCtrlWord[19:0] = 20'd3; step(40);
    pulseAcc(1); step(70);
    // R3: zero setting gives 15-cycle reload
    curTag = "R3";
    quietCtrlWord[19:0] = 20'd0; pulseAcc(1); step(25);
    // R1: reset again mid-countdown, enable off
    curTag = "R1";
    quietCtrlWord = {1'b0, 20'd2}; pulseAcc(0);
    rstN = 1'b0; step(2); rstN = 1'b1;
    curTag = "R6"; step(60);
    quietCtrlWord[20] = 1'b1; step(5);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog irq=%0b expected completion", core0QuietIrq);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule